// File: doc/BRIEF.md
# Relocatable Register Window Decoder

This block watches every bus cycle and decides whether the cycle targets a 256-byte window of on-chip 16-bit registers. The window can be moved. It can sit on any 256-byte-aligned base in the 20-bit address range, in either memory space or I/O space. The base, the space and two mode bits are all held in a 16-bit relocation word. That word is itself one of the registers inside the window, at byte offset FEh.

When a cycle falls inside the window, the block raises a hit flag and reports the byte offset to the register file. It also tells the bus interface to ignore the external data and ready inputs for that cycle. The external bus still runs a normal, visible cycle. The two mode outputs feed the interrupt controller (slave operation) and the instruction decoder (trap on escape opcodes).

The decode result is captured when a cycle starts, marked by `cyc_start`. It holds until the next cycle starts. Because of this, a write that moves the window finishes at the old location, and the new placement applies from the following cycle onward.

Top module: `pcb_window_decoder`

## Requirements
- R1: After reset the relocation word reads 00FFh: base field FFh, I/O space, slave mode and escape trap both 0. The window therefore covers I/O addresses FF00h to FFFFh.
- R2: `hit` is 1 when, at the clock edge where `cyc_start` is 1, `cyc_is_mem` equals the word's space bit and `cyc_addr[19:8]` equals the word's bits 11:0. `hit` appears the cycle after that edge and holds until the next cycle start.
- R3: `reg_ofs` shows `cyc_addr[7:0]` captured at the cycle start when `hit` is 1, and shows 0 when `hit` is 0.
- R4: A cycle whose address matches but whose space flag differs from the word's bit 12 (1 = memory, 0 = I/O) does not hit.
- R5: A write (`wr_stb` = 1 while `hit` = 1 and `reg_ofs[7:1]` = 7Fh) updates only the enabled byte lanes: `byte_en[0]` covers bits 7:0 and `byte_en[1]` covers bits 15:8.
- R6: Bit 13 of the relocation word always reads 0, even after a 1 is written there.
- R7: A write that moves the window leaves `hit` at 1 for the rest of that cycle. The next cycle decodes against the new base and space only.
- R8: `ext_ignore` equals `hit`. It tells the bus interface to ignore external data and ready for internal cycles.
- R9: `slave_mode` shows bit 14 of the word and `esc_trap` shows bit 15.
- R10: `reloc_rdata` shows the relocation word when `hit`, `rd_stb` and `reg_ofs[7:1]` = 7Fh are all 1, and shows 0 in every other case.
- R11: A write during a missed cycle, or to any other offset in the window, leaves the relocation word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Pulses at the start of a bus cycle; address and space are valid |
| cyc_addr | input | 20 | Bus cycle address |
| cyc_is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_stb | input | 1 | Read strobe of the current cycle |
| wr_stb | input | 1 | Write strobe of the current cycle |
| byte_en | input | 2 | Byte lane enables for writes |
| wr_data | input | 16 | Write data |
| hit | output | 1 | The current cycle targets the register window |
| reg_ofs | output | 8 | Byte offset inside the window (0 on a miss) |
| reloc_rdata | output | 16 | Relocation word read data |
| slave_mode | output | 1 | Interrupt controller slave mode |
| esc_trap | output | 1 | Trap on escape opcodes |
| ext_ignore | output | 1 | Ignore external data and ready inputs |

## Verification
`hit`, `reg_ofs` and `ext_ignore` come from a register loaded at the `cyc_start` edge. The bench therefore samples them at the falling edge one half-period after that edge. `reloc_rdata` is combinational from the strobes and the stored word, so it is sampled 1 ns after the strobe changes. A write is loaded at the rising edge inside its strobe window. Its effect is checked at the next falling edge for the mode outputs, and for the base only after a fresh `cyc_start`. This is how the bench confirms that the cycle in progress keeps its old decode.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
   localparam int unsigned ADDR_W   = 20;
   localparam int unsigned DATA_W   = 16;
   localparam int unsigned WIN_W    = 8;
   localparam int unsigned BASE_W   = ADDR_W - WIN_W;
   localparam int unsigned LANES    = DATA_W / 8;
   localparam int unsigned SPACE_B  = 12;
   localparam int unsigned ZERO_B   = 13;
   localparam int unsigned SLAVE_B  = 14;
   localparam int unsigned ESC_B    = 15;

   typedef struct packed {
      logic             hit;
      logic [WIN_W-1:0] ofs;
   } decode_t;

   function automatic logic [DATA_W-1:0] make_word(
      input logic [BASE_W-1:0] base, input logic mem,
      input logic slave, input logic esc);
      logic [DATA_W-1:0] w;
      w = '0;
      w[BASE_W-1:0] = base;
      w[SPACE_B]    = mem;
      w[SLAVE_B]    = slave;
      w[ESC_B]      = esc;
      return w;
   endfunction
endpackage

// File: rtl/pcb_addr_match.sv
module pcb_addr_match #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned WIN_W  = 8,
   localparam int unsigned BASE_W = ADDR_W - WIN_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_mem,
   input  logic [BASE_W-1:0] base,
   input  logic              space_mem,
   output logic              match
);
   logic page_eq;
   logic space_eq;

   assign page_eq  = (addr[ADDR_W-1:WIN_W] == base);
   assign space_eq = (is_mem == space_mem);
   assign match    = page_eq & space_eq;
endmodule

// File: rtl/pcb_cycle_latch.sv
module pcb_cycle_latch
   import pcb_pkg::*;
#(
   parameter int unsigned OFS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             match,
   input  logic [OFS_W-1:0] ofs_in,
   output logic             hit_q,
   output logic [OFS_W-1:0] ofs_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         ofs_q <= '0;
      end else if (start) begin
         hit_q <= match;
         ofs_q <= match ? ofs_in : '0;
      end
   end
endmodule

// File: rtl/pcb_reloc_reg.sv
module pcb_reloc_reg #(
   parameter int unsigned        DATA_W    = 16,
   parameter logic [DATA_W-1:0]  RST_WORD  = 16'h00FF,
   parameter logic [DATA_W-1:0]  KEEP_MASK = 16'hDFFF,
   localparam int unsigned       LANES     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [LANES-1:0]  lane_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] word_q
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[8*l +: 8] <= RST_WORD[8*l +: 8] & KEEP_MASK[8*l +: 8];
         else if (wr_en && lane_en[l])
            word_q[8*l +: 8] <= wdata[8*l +: 8] & KEEP_MASK[8*l +: 8];
      end
   end
endmodule

// File: rtl/pcb_window_decoder.sv
module pcb_window_decoder
   import pcb_pkg::*;
#(
   parameter logic [BASE_W-1:0] RST_BASE  = 12'h0FF,
   parameter logic              RST_MEM   = 1'b0,
   parameter logic [WIN_W-1:0]  RELOC_OFS = 8'hFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic              cyc_is_mem,
   input  logic              rd_stb,
   input  logic              wr_stb,
   input  logic [LANES-1:0]  byte_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit,
   output logic [WIN_W-1:0]  reg_ofs,
   output logic [DATA_W-1:0] reloc_rdata,
   output logic              slave_mode,
   output logic              esc_trap,
   output logic              ext_ignore
);
   localparam logic [DATA_W-1:0] RST_WORD  = make_word(RST_BASE, RST_MEM, 1'b0, 1'b0);
   localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << ZERO_B);

   if (DATA_W != 16) begin : g_bad_width
      $error("relocation word must be 16 bits");
   end
   if (BASE_W > SPACE_B) begin : g_bad_base
      $error("base field overlaps the space bit");
   end
   if (RELOC_OFS[0] != 1'b0) begin : g_bad_ofs
      $error("relocation offset must be word aligned");
   end

   logic [DATA_W-1:0] word_q;
   logic              match;
   logic              at_reloc;
   logic              wr_en;
   decode_t           dec;

   pcb_addr_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_match (
      .addr      (cyc_addr),
      .is_mem    (cyc_is_mem),
      .base      (word_q[BASE_W-1:0]),
      .space_mem (word_q[SPACE_B]),
      .match     (match)
   );

   pcb_cycle_latch #(.OFS_W(WIN_W)) i_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cyc_start),
      .match  (match),
      .ofs_in (cyc_addr[WIN_W-1:0]),
      .hit_q  (dec.hit),
      .ofs_q  (dec.ofs)
   );

   assign at_reloc = dec.hit && (dec.ofs[WIN_W-1:1] == RELOC_OFS[WIN_W-1:1]);
   assign wr_en    = at_reloc && wr_stb;

   pcb_reloc_reg #(.DATA_W(DATA_W), .RST_WORD(RST_WORD), .KEEP_MASK(KEEP_MASK)) i_reloc (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .lane_en (byte_en),
      .wdata   (wr_data),
      .word_q  (word_q)
   );

   assign hit         = dec.hit;
   assign reg_ofs     = dec.ofs;
   assign ext_ignore  = dec.hit;
   assign reloc_rdata = (at_reloc && rd_stb) ? word_q : '0;
   assign slave_mode  = word_q[SLAVE_B];
   assign esc_trap    = word_q[ESC_B];
endmodule

// File: rtl/pcb_window_decoder_chk.sv
module pcb_window_decoder_chk
   import pcb_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_start,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic              hit,
   input logic [WIN_W-1:0]  reg_ofs,
   input logic [DATA_W-1:0] reloc_rdata,
   input logic              slave_mode,
   input logic              esc_trap
);
   a_r2_hit_held: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_start |=> $stable(hit));
   a_r3_ofs_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> reg_ofs == '0);
   a_r6_bit13_zero: assert property (@(posedge clk) disable iff (!rst_n)
      reloc_rdata[ZERO_B] == 1'b0);
   a_r9_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(slave_mode) && $stable(esc_trap));
   a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && rd_stb) |-> reloc_rdata == '0);
endmodule

bind pcb_window_decoder pcb_window_decoder_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .rd_stb(rd_stb),
   .wr_stb(wr_stb), .hit(hit), .reg_ofs(reg_ofs), .reloc_rdata(reloc_rdata),
   .slave_mode(slave_mode), .esc_trap(esc_trap)
);

// File: tb/test_pcb_window_decoder.sv
module test_pcb_window_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_start = 1'b0;
   logic [19:0] cyc_addr = '0;
   logic        cyc_is_mem = 1'b0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic [1:0]  byte_en = 2'b00;
   logic [15:0] wr_data = '0;
   logic        hit;
   logic [7:0]  reg_ofs;
   logic [15:0] reloc_rdata;
   logic        slave_mode, esc_trap, ext_ignore;
   int          n_run = 0;
   int          n_fail = 0;

   always #5 clk = ~clk;

   pcb_window_decoder i_pcb_window_decoder (.*);

   // {addr[19:0], is_mem, expected hit} against the reset window (I/O FF00h)
   localparam int NV = 6;
   localparam logic [21:0] VEC [NV] = '{
      {20'h0FF00, 1'b0, 1'b1},
      {20'h0FF42, 1'b0, 1'b1},
      {20'h0FFFE, 1'b0, 1'b1},
      {20'h0FF00, 1'b1, 1'b0},
      {20'h0FE80, 1'b0, 1'b0},
      {20'h1FF00, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // start a cycle; returns at the falling edge after the decode edge
   task automatic start_cycle(input logic [19:0] a, input logic mem);
      @(negedge clk);
      cyc_start = 1'b1; cyc_addr = a; cyc_is_mem = mem;
      @(negedge clk);
      cyc_start = 1'b0;
   endtask

   task automatic do_write(input logic [1:0] be, input logic [15:0] d);
      wr_stb = 1'b1; byte_en = be; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0; byte_en = 2'b00;
   endtask

   task automatic read_word(input string req, input logic [15:0] exp);
      rd_stb = 1'b1; #1;
      check(req, reloc_rdata, exp);
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 hit", hit, 0);
      check("R1 slave", slave_mode, 0);
      check("R1 esc", esc_trap, 0);
      // R2 R3 R4 R8 vector walk
      for (int i = 0; i < NV; i++) begin
         start_cycle(VEC[i][21:2], VEC[i][1]);
         check("R2 R4 hit", hit, VEC[i][0]);
         check("R3 ofs", reg_ofs, VEC[i][0] ? VEC[i][9:2] : 8'h00);
         check("R8 ext_ignore", ext_ignore, VEC[i][0]);
      end
      // R1 R10 reset word readback
      start_cycle(20'h0FFFE, 1'b0);
      read_word("R1 R10 reset word", 16'h00FF);
      // R10 read of another offset gives zero
      start_cycle(20'h0FF10, 1'b0);
      read_word("R10 other offset", 16'h0000);
      // R5 R6 R7 R9 full write: base 234h, memory, bit13 set, both modes
      start_cycle(20'h0FFFE, 1'b0);
      do_write(2'b11, 16'hF234);
      check("R7 hit holds", hit, 1);
      check("R9 slave", slave_mode, 1);
      check("R9 esc", esc_trap, 1);
      start_cycle(20'h0FF00, 1'b0);
      check("R7 old window gone", hit, 0);
      start_cycle(20'h234FE, 1'b1);
      check("R7 new window", hit, 1);
      read_word("R6 bit13 cleared", 16'hD234);
      // R5 low lane only
      start_cycle(20'h234FE, 1'b1);
      do_write(2'b01, 16'hAA56);
      start_cycle(20'h256FE, 1'b1);
      check("R5 low lane moved base", hit, 1);
      read_word("R5 low lane", 16'hD256);
      // R5 high lane only (odd byte address)
      start_cycle(20'h256FF, 1'b1);
      do_write(2'b10, 16'h0011);
      check("R9 slave cleared", slave_mode, 0);
      start_cycle(20'h05610, 1'b0);
      check("R5 high lane to I/O", hit, 1);
      start_cycle(20'h05610, 1'b1);
      check("R4 space mismatch", hit, 0);
      // R11 writes that must be ignored
      start_cycle(20'h0FFFE, 1'b0);
      check("R11 miss cycle", hit, 0);
      do_write(2'b11, 16'hFFFF);
      start_cycle(20'h056FC, 1'b0);
      do_write(2'b11, 16'hFFFF);
      check("R11 esc unchanged", esc_trap, 0);
      start_cycle(20'h056FE, 1'b0);
      read_word("R11 word unchanged", 16'h0056);
      // R1 reset returns the window
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      start_cycle(20'h0FF20, 1'b0);
      check("R1 window after reset", hit, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule